// File: doc/BRIEF.md
# Received-Power Measurement Sequencer

This block decides when a received-power average is taken. It waits for a restart event. Each of six restart modes picks which event counts. After the event it lets the receive path settle for a programmed delay. It then runs measurement windows over incoming squared-magnitude samples, separated by idle gaps, until a programmed total duration has passed. At the end of each completed window, the window's average power is placed on the output, together with a single-cycle ready strobe.

Delay, gap and total duration are counted in one of two units, selected by a configuration bit: receive-sample strobes or microsecond ticks. The window length is always a power-of-two number of samples, so the average is a right shift of the sum. A new restart event always wins. It throws away any partial window and begins again with the settling delay. Once the duration runs out, the block stays quiet until the next restart event.

Top module: `pwr_meas_seq`

## Requirements
- R1: After reset, `rssi_out` is 0 and `rssi_rdy` is 0. The block is idle, so samples produce no result until a restart event arrives.
- R2: `cfg_mode` picks the restart source. The encoding is 0 = gain-lock event, 1 = rising edge of `agc_en_pin`, 2 = receive-entry event, 3 = gain-change event, 4 = register-write event, 5 = gain-change event or rising edge of `agc_en_pin`. Codes 6 and 7 never restart. Events from sources that are not selected have no effect.
- R3: In modes 1 and 5, only a 0-to-1 change of `agc_en_pin` counts. A steady high level does not restart the block.
- R4: After a restart, the first `cfg_delay` unit ticks are not accumulated. With `cfg_delay` = 0, the first sample after the restart cycle is already part of a window.
- R5: A window holds 2^`cfg_meas_log2` samples. `rssi_out` becomes floor(sum / 2^`cfg_meas_log2`) and `rssi_rdy` is high for one cycle, in the cycle after the window's last sample. `rssi_out` changes only when `rssi_rdy` is high.
- R6: After each window, the next `cfg_wait` unit ticks are not accumulated. With `cfg_wait` = 0, windows follow back to back.
- R7: When `cfg_unit_us` = 1, delay, gap and duration count `us_tick` pulses. When it is 0, they count `samp_vld` strobes. The window length is always counted in samples.
- R8: A restart event in any phase discards the partial window sum and begins a new settling delay. Samples taken before the restart do not affect any later result.
- R9: Unit ticks are numbered from 1, starting after the restart. On tick number `cfg_duration` the sequence ends. A window still open at that point is discarded, including a sample that arrives on that same tick. The block then stays idle until the next restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 3 | Restart source select |
| cfg_unit_us | input | 1 | 1: count microsecond ticks; 0: count sample strobes |
| cfg_delay | input | CNT_W | Settling delay in units |
| cfg_wait | input | CNT_W | Gap between windows in units |
| cfg_duration | input | DUR_W | Total run length in units |
| cfg_meas_log2 | input | LOG_W | Log2 of window length in samples |
| samp_vld | input | 1 | Sample strobe |
| samp_pwr | input | SAMP_W | Squared-magnitude sample |
| us_tick | input | 1 | One-cycle microsecond tick |
| evt_gain_lock | input | 1 | Gain-lock event pulse |
| agc_en_pin | input | 1 | Gain-control enable pin level |
| evt_rx_enter | input | 1 | Receive-entry event pulse |
| evt_gain_chg | input | 1 | Gain-change event pulse |
| evt_reg_wr | input | 1 | Register-write event pulse |
| rssi_out | output | SAMP_W | Latched window average |
| rssi_rdy | output | 1 | One-cycle strobe with a new average |

## Verification
A phase counter that runs long or short shifts which samples fall into a window. This shows up as a wrong average, or as a missing or extra ready strobe, on the first window after the restart. A stale accumulator or sample count after a restart or an expiry corrupts the very next `rssi_out` value. A wrong restart decode shows up as a missing or spurious strobe one cycle after the first sample that follows the event. Sweeps cover every mode against every source, together with arithmetic window sums for several delay, gap, duration and window settings.

// File: rtl/pwr_meas_pkg.sv
package pwr_meas_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_DELAY = 2'd1,
      PH_MEAS  = 2'd2,
      PH_WAIT  = 2'd3
   } phase_e;

   localparam logic [2:0] RS_LOCK      = 3'd0;
   localparam logic [2:0] RS_PIN       = 3'd1;
   localparam logic [2:0] RS_RXENTRY   = 3'd2;
   localparam logic [2:0] RS_GAIN      = 3'd3;
   localparam logic [2:0] RS_WRITE     = 3'd4;
   localparam logic [2:0] RS_GAIN_PIN  = 3'd5;
endpackage

// File: rtl/pwr_trig_sel.sv
module pwr_trig_sel
   import pwr_meas_pkg::*;
#(
   parameter int SYNC_STAGES = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] mode,
   input  logic       evt_lock,
   input  logic       pin,
   input  logic       evt_rx,
   input  logic       evt_gain,
   input  logic       evt_wr,
   output logic       restart
);
   logic pin_s;
   logic pin_q;
   logic pin_rise;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign pin_s = pin;
      end else begin : g_sync
         logic [SYNC_STAGES:0] chain;
         assign chain[0] = pin;
         for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_st
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i+1] <= 1'b0;
               else        chain[i+1] <= chain[i];
            end
         end
         assign pin_s = chain[SYNC_STAGES];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= 1'b0;
      else        pin_q <= pin_s;
   end

   assign pin_rise = pin_s & ~pin_q;

   always_comb begin
      unique case (mode)
         RS_LOCK:     restart = evt_lock;
         RS_PIN:      restart = pin_rise;
         RS_RXENTRY:  restart = evt_rx;
         RS_GAIN:     restart = evt_gain;
         RS_WRITE:    restart = evt_wr;
         RS_GAIN_PIN: restart = evt_gain | pin_rise;
         default:     restart = 1'b0;
      endcase
   end

   // R3: a held-high pin must not keep restarting
   a_r3_level_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == RS_PIN && pin_s && $past(pin_s)) |-> !restart);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
   import pwr_meas_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int DUR_W = 12,
   parameter int LOG_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             unit_us,
   input  logic [CNT_W-1:0] cfg_delay,
   input  logic [CNT_W-1:0] cfg_wait,
   input  logic [DUR_W-1:0] cfg_dur,
   input  logic [LOG_W-1:0] cfg_log2,
   input  logic             samp_vld,
   input  logic             us_tick,
   output logic             acc_clr,
   output logic             acc_add,
   output logic             acc_done
);
   localparam int MAXL = (1 << LOG_W) - 1;
   localparam int SC_W = (MAXL > 0) ? MAXL : 1;

   phase_e           phase;
   logic [CNT_W-1:0] dcnt;
   logic [DUR_W-1:0] dur_cnt;
   logic [SC_W-1:0]  scnt;
   logic [SC_W-1:0]  last_idx;
   logic [CNT_W-1:0] lim;
   logic             ut;
   logic             dur_hit;
   logic             cnt_hit;
   logic             win_last;

   assign ut       = unit_us ? us_tick : samp_vld;
   assign last_idx = {SC_W{1'b1}} >> (SC_W - int'(cfg_log2));
   assign win_last = (scnt == last_idx);
   assign lim      = (phase == PH_DELAY) ? cfg_delay : cfg_wait;
   assign cnt_hit  = ({1'b0, dcnt} + 1'b1) >= {1'b0, lim};
   assign dur_hit  = (phase != PH_IDLE) && ut &&
                     (({1'b0, dur_cnt} + 1'b1) >= {1'b0, cfg_dur});

   assign acc_add  = (phase == PH_MEAS) && samp_vld && !restart && !dur_hit;
   assign acc_done = acc_add && win_last;
   assign acc_clr  = restart | dur_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         dcnt    <= '0;
         dur_cnt <= '0;
         scnt    <= '0;
      end else if (restart) begin
         phase   <= (cfg_delay == '0) ? PH_MEAS : PH_DELAY;
         dcnt    <= '0;
         dur_cnt <= '0;
         scnt    <= '0;
      end else if (phase != PH_IDLE) begin
         if (dur_hit) begin
            phase   <= PH_IDLE;
            dcnt    <= '0;
            dur_cnt <= '0;
            scnt    <= '0;
         end else begin
            if (ut) dur_cnt <= dur_cnt + 1'b1;
            unique case (phase)
               PH_DELAY, PH_WAIT: begin
                  if (ut) begin
                     if (cnt_hit) begin
                        phase <= PH_MEAS;
                        dcnt  <= '0;
                     end else begin
                        dcnt <= dcnt + 1'b1;
                     end
                  end
               end
               PH_MEAS: begin
                  if (samp_vld) begin
                     if (win_last) begin
                        phase <= (cfg_wait == '0) ? PH_MEAS : PH_WAIT;
                        scnt  <= '0;
                     end else begin
                        scnt <= scnt + 1'b1;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   a_r8_restart_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (phase != PH_IDLE));
   a_r9_expiry_idles: assert property (@(posedge clk) disable iff (!rst_n)
      (dur_hit && !restart) |=> (phase == PH_IDLE));
   a_r6_gap_follows_window: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_done && cfg_wait != '0) |=> (phase == PH_WAIT));
   a_r4_delay_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && cfg_delay != '0) |=> (phase == PH_DELAY));
endmodule

// File: rtl/pwr_accum.sv
module pwr_accum #(
   parameter int SAMP_W = 12,
   parameter int LOG_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_clr,
   input  logic              acc_add,
   input  logic              acc_done,
   input  logic [LOG_W-1:0]  cfg_log2,
   input  logic [SAMP_W-1:0] samp_pwr,
   output logic [SAMP_W-1:0] rssi_out,
   output logic              rssi_rdy
);
   localparam int MAXL  = (1 << LOG_W) - 1;
   localparam int ACC_W = SAMP_W + MAXL;

   logic [ACC_W-1:0] acc;
   logic [ACC_W-1:0] acc_sum;
   logic [ACC_W-1:0] acc_avg;

   assign acc_sum = acc + ACC_W'(samp_pwr);
   assign acc_avg = acc_sum >> cfg_log2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc      <= '0;
         rssi_out <= '0;
         rssi_rdy <= 1'b0;
      end else begin
         rssi_rdy <= 1'b0;
         if (acc_clr) begin
            acc <= '0;
         end else if (acc_done) begin
            acc      <= '0;
            rssi_out <= acc_avg[SAMP_W-1:0];
            rssi_rdy <= 1'b1;
         end else if (acc_add) begin
            acc <= acc_sum;
         end
      end
   end

   a_r5_out_held: assert property (@(posedge clk) disable iff (!rst_n)
      !rssi_rdy |-> $stable(rssi_out));
endmodule

// File: rtl/pwr_meas_seq.sv
module pwr_meas_seq
   import pwr_meas_pkg::*;
#(
   parameter int SAMP_W      = 12,
   parameter int CNT_W       = 8,
   parameter int DUR_W       = 12,
   parameter int LOG_W       = 3,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cfg_mode,
   input  logic              cfg_unit_us,
   input  logic [CNT_W-1:0]  cfg_delay,
   input  logic [CNT_W-1:0]  cfg_wait,
   input  logic [DUR_W-1:0]  cfg_duration,
   input  logic [LOG_W-1:0]  cfg_meas_log2,
   input  logic              samp_vld,
   input  logic [SAMP_W-1:0] samp_pwr,
   input  logic              us_tick,
   input  logic              evt_gain_lock,
   input  logic              agc_en_pin,
   input  logic              evt_rx_enter,
   input  logic              evt_gain_chg,
   input  logic              evt_reg_wr,
   output logic [SAMP_W-1:0] rssi_out,
   output logic              rssi_rdy
);
   generate
      if (SAMP_W < 2)              begin : g_bad_samp  $error("SAMP_W must be at least 2"); end
      if (CNT_W < 1)               begin : g_bad_cnt   $error("CNT_W must be positive"); end
      if (DUR_W < 1)               begin : g_bad_dur   $error("DUR_W must be positive"); end
      if (LOG_W < 1 || LOG_W > 4)  begin : g_bad_log   $error("LOG_W must be 1..4"); end
      if (SYNC_STAGES < 0)         begin : g_bad_sync  $error("SYNC_STAGES must be >= 0"); end
   endgenerate

   logic restart;
   logic acc_clr;
   logic acc_add;
   logic acc_done;

   pwr_trig_sel #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (cfg_mode),
      .evt_lock (evt_gain_lock),
      .pin      (agc_en_pin),
      .evt_rx   (evt_rx_enter),
      .evt_gain (evt_gain_chg),
      .evt_wr   (evt_reg_wr),
      .restart  (restart)
   );

   pwr_seq_ctrl #(.CNT_W(CNT_W), .DUR_W(DUR_W), .LOG_W(LOG_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (restart),
      .unit_us   (cfg_unit_us),
      .cfg_delay (cfg_delay),
      .cfg_wait  (cfg_wait),
      .cfg_dur   (cfg_duration),
      .cfg_log2  (cfg_meas_log2),
      .samp_vld  (samp_vld),
      .us_tick   (us_tick),
      .acc_clr   (acc_clr),
      .acc_add   (acc_add),
      .acc_done  (acc_done)
   );

   pwr_accum #(.SAMP_W(SAMP_W), .LOG_W(LOG_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_clr  (acc_clr),
      .acc_add  (acc_add),
      .acc_done (acc_done),
      .cfg_log2 (cfg_meas_log2),
      .samp_pwr (samp_pwr),
      .rssi_out (rssi_out),
      .rssi_rdy (rssi_rdy)
   );

   a_r5_rdy_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      acc_done |=> rssi_rdy);
   a_r5_no_spurious_rdy: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_done |=> !rssi_rdy);
endmodule

// File: tb/test_pwr_meas_seq.sv
module test_pwr_meas_seq;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cfg_mode = 3'd4;
   logic        cfg_unit_us = 1'b0;
   logic [7:0]  cfg_delay = 8'd0;
   logic [7:0]  cfg_wait = 8'd0;
   logic [11:0] cfg_duration = 12'd100;
   logic [2:0]  cfg_meas_log2 = 3'd0;
   logic        samp_vld = 1'b0;
   logic [11:0] samp_pwr = 12'd0;
   logic        us_tick = 1'b0;
   logic        evt_gain_lock = 1'b0;
   logic        agc_en_pin = 1'b0;
   logic        evt_rx_enter = 1'b0;
   logic        evt_gain_chg = 1'b0;
   logic        evt_reg_wr = 1'b0;
   logic [11:0] rssi_out;
   logic        rssi_rdy;

   int n_checks = 0;
   int n_errors = 0;
   logic [11:0] got_q[$];

   always #(CLK_P/2) clk = ~clk;

   pwr_meas_seq i_pwr_meas_seq (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_unit_us(cfg_unit_us),
      .cfg_delay(cfg_delay), .cfg_wait(cfg_wait), .cfg_duration(cfg_duration),
      .cfg_meas_log2(cfg_meas_log2), .samp_vld(samp_vld), .samp_pwr(samp_pwr),
      .us_tick(us_tick), .evt_gain_lock(evt_gain_lock), .agc_en_pin(agc_en_pin),
      .evt_rx_enter(evt_rx_enter), .evt_gain_chg(evt_gain_chg), .evt_reg_wr(evt_reg_wr),
      .rssi_out(rssi_out), .rssi_rdy(rssi_rdy)
   );

   always @(negedge clk) if (rssi_rdy) got_q.push_back(rssi_out);

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      got_q.delete();
   endtask

   task automatic sample(input int v);
      @(negedge clk);
      samp_vld = 1'b1;
      samp_pwr = 12'(v);
      @(negedge clk);
      samp_vld = 1'b0;
   endtask

   task automatic utick();
      @(negedge clk);
      us_tick = 1'b1;
      @(negedge clk);
      us_tick = 1'b0;
   endtask

   task automatic fire(input int src);
      @(negedge clk);
      case (src)
         0: evt_gain_lock = 1'b1;
         1: agc_en_pin = 1'b1;
         2: evt_rx_enter = 1'b1;
         3: evt_gain_chg = 1'b1;
         4: evt_reg_wr = 1'b1;
         default: ;
      endcase
      @(negedge clk);
      evt_gain_lock = 1'b0;
      evt_rx_enter = 1'b0;
      evt_gain_chg = 1'b0;
      evt_reg_wr = 1'b0;
   endtask

   function automatic int val(input int k, input int kind);
      return (kind == 1) ? 4095 : ((k * 373 + 29) % 4096);
   endfunction

   // Sample-unit run: optional aborted prelude, then n samples after a fresh restart
   task automatic run_case(input string req, input int d, input int l, input int w,
                           input int t, input int n, input int kind, input int pre);
      int nw;
      int s;
      int exp_v[$];
      do_reset();
      cfg_mode = 3'd4; cfg_unit_us = 1'b0;
      cfg_delay = 8'(d); cfg_wait = 8'(w); cfg_duration = 12'(t); cfg_meas_log2 = 3'(l);
      if (pre > 0) begin
         fire(4);
         for (int k = 0; k < pre; k++) sample(4000);
      end
      fire(4);
      got_q.delete();
      for (int k = 0; k < n; k++) sample(val(k, kind));
      repeat (3) @(negedge clk);
      nw = 1 << l;
      s = d;
      while ((s + nw - 1 <= t - 2) && (s + nw - 1 <= n - 1)) begin
         int sum = 0;
         for (int j = 0; j < nw; j++) sum += val(s + j, kind);
         exp_v.push_back(sum >> l);
         s += nw + w;
      end
      check({req, " result count"}, got_q.size(), exp_v.size());
      for (int i = 0; i < exp_v.size() && i < got_q.size(); i++)
         check({req, " window average"}, int'(got_q[i]), exp_v[i]);
   endtask

   initial begin
      #(CLK_P * 150000);
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      // R1: reset state, and idle block ignores samples
      do_reset();
      check("R1 rssi_out reset", int'(rssi_out), 0);
      check("R1 rssi_rdy reset", int'(rssi_rdy), 0);
      sample(123);
      repeat (2) @(negedge clk);
      check("R1 idle no result", got_q.size(), 0);

      // R2/R3: every mode against every source
      for (int m = 0; m < 8; m++) begin
         for (int src = 0; src < 5; src++) begin
            int acc;
            do_reset();
            cfg_mode = 3'(m); cfg_unit_us = 1'b0;
            cfg_delay = 8'd0; cfg_wait = 8'd0; cfg_duration = 12'd100; cfg_meas_log2 = 3'd0;
            fire(src);
            repeat (2) @(negedge clk);
            sample(85);
            repeat (2) @(negedge clk);
            acc = ((m == src) && m < 5) || (m == 5 && (src == 3 || src == 1)) ? 1 : 0;
            check((src == 1) ? "R3 pin edge restart select" : "R2 restart select",
                  got_q.size(), acc);
            if (acc == 1 && got_q.size() == 1) check("R2 single-sample value", int'(got_q[0]), 85);
            agc_en_pin = 1'b0;
         end
      end

      // R3: pin already high at restart-check time gives no new restart
      do_reset();
      cfg_mode = 3'd1; cfg_delay = 8'd0; cfg_duration = 12'd2; cfg_meas_log2 = 3'd0;
      fire(1);
      sample(10); sample(20);
      repeat (3) @(negedge clk);
      got_q.delete();
      sample(30);
      repeat (2) @(negedge clk);
      check("R3 held level no restart", got_q.size(), 0);
      agc_en_pin = 1'b0;

      run_case("R4 R5 R6 R9 delay gap", 3, 2, 2, 30, 40, 0, 0);
      run_case("R4 R6 zero delay zero gap", 0, 0, 0, 5, 8, 0, 0);
      run_case("R5 full-scale average", 1, 3, 0, 20, 30, 1, 0);
      run_case("R9 short duration", 2, 1, 1, 6, 12, 0, 0);
      run_case("R8 abort mid window", 3, 2, 2, 30, 40, 0, 5);
      run_case("R8 abort in delay", 4, 1, 3, 25, 30, 0, 2);

      // R7: microsecond units for delay/gap/duration
      do_reset();
      cfg_mode = 3'd4; cfg_unit_us = 1'b1;
      cfg_delay = 8'd2; cfg_wait = 8'd1; cfg_duration = 12'd10; cfg_meas_log2 = 3'd1;
      fire(4);
      sample(100); utick(); sample(200); utick();
      sample(300); sample(500);
      utick();
      sample(1000); sample(2000);
      for (int k = 0; k < 6; k++) utick();
      sample(111); utick(); sample(222);
      repeat (3) @(negedge clk);
      check("R7 us-unit result count", got_q.size(), 2);
      if (got_q.size() >= 2) begin
         check("R7 us-unit first average", int'(got_q[0]), 400);
         check("R7 us-unit second average", int'(got_q[1]), 1500);
      end
      check("R9 idle output holds", int'(rssi_out), 1500);
      cfg_unit_us = 1'b0;

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule